// File: doc/BRIEF.md
# Per-Channel Conversion Ready Tracker

This block keeps one ready flag for each converter channel and the most recent result of every channel. A converter hands in a finished result with its channel index. A host reads results back by channel index, either at full width or as a shortened word. Each flag tells the host whether its channel holds a result that has not yet been read. The flags together form a status word, and an active-low ready pin is derived from that word.

Flags are cleared by a read, by a mode-register write, and by a calibration. A result that arrives for a channel whose previous result was never read causes that channel's flag to drop for one cycle and then rise again. A host that polls the flag can therefore see that data was overwritten. A calibration holds every flag low for as long as it runs, and it raises all flags together when it finishes.

Result intake is a valid/ready stream. The block is always ready, except while a calibration is running. During a calibration `cvt_ready` is low, and a result offered while `cvt_ready` is low is neither stored nor flagged. The source must hold or drop it. The read port has no back-pressure: every `rd_req` is answered exactly one cycle later.

Top module: `rdy_tracker`

## Requirements
- R1: During and directly after reset, `status` is 0, `rdy_n` is 1, `rd_data_vld` is 0 and `cvt_ready` is 1. All stored results are 0.
- R2: An accepted result (`cvt_valid` and `cvt_ready` both high) whose channel flag is clear is stored for channel `cvt_ch`. It sets `status[cvt_ch]` from the next cycle on.
- R3: A `rd_req` for channel `rd_ch` makes `rd_data_vld` high in the next cycle, with that channel's result on `rd_data`. It clears `status[rd_ch]` from the next cycle on.
- R4: If an accepted result and a read target the same channel in the same cycle, the flag of that channel is set afterwards.
- R5: If an accepted result arrives for a channel whose flag is already set, and no read of that channel happens in the same cycle, the flag is 0 for exactly one cycle and then 1 again. A read of that channel during the low cycle keeps the flag at 0.
- R6: `mode_wr` clears all flags in the next cycle. It takes priority over a result accepted in the same cycle, although the result is still stored.
- R7: `cal_start` clears all flags and drops `cvt_ready` from the next cycle on. Flags stay 0 and results are refused until `cal_done`. After `cal_done`, all flags are 1 and `cvt_ready` is 1.
- R8: With `rdy_fn` = 0, `rdy_n` is 0 exactly when at least one flag is set.
- R9: With `rdy_fn` = 1, `rdy_n` is 0 exactly when `chan_en` is nonzero and every channel enabled in `chan_en` has its flag set.
- R10: A read with `rd_short` = 1 returns the upper 16 bits of the result in `rd_data[15:0]`, with `rd_data[23:16]` at 0.
- R11: A read returns the result held before the clock edge, so a result accepted for that channel in the same cycle is not visible to that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cvt_valid | input | 1 | Result offered |
| cvt_ready | output | 1 | Result can be accepted (low during calibration) |
| cvt_ch | input | 3 | Channel of offered result |
| cvt_data | input | 24 | Offered result |
| rd_req | input | 1 | Read request pulse |
| rd_ch | input | 3 | Channel to read |
| rd_short | input | 1 | 1 = return upper 16 bits only |
| rd_data_vld | output | 1 | Read response valid |
| rd_data | output | 24 | Read response data |
| mode_wr | input | 1 | Mode-register write strobe |
| cal_start | input | 1 | Calibration start pulse |
| cal_done | input | 1 | Calibration finished pulse |
| rdy_fn | input | 1 | Ready pin function: 0 = any flag, 1 = all enabled |
| chan_en | input | 8 | Enabled channel mask for function 1 |
| status | output | 8 | Ready flags, bit n for channel n |
| rdy_n | output | 1 | Active-low ready pin |

## Verification
The properties assume that `cal_done` is pulsed only while a calibration is running, that is, while `cvt_ready` is low. They also assume that `rd_ch` and `cvt_ch` are always valid channel numbers. The stimulus issues `cal_done` only after it has issued `cal_start`. Both in the directed sequences and in the randomized phase, it draws channel indices from the legal range. Same-cycle collisions of result, read, mode write and calibration start are produced on purpose, so that each priority rule is exercised.

// File: rtl/rdy_trk_pkg.sv
package rdy_trk_pkg;
  typedef enum logic {
    PIN_ANY = 1'b0,
    PIN_ALL = 1'b1
  } pin_fn_e;
endpackage

// File: rtl/rdy_flag_ctrl.sv
module rdy_flag_ctrl #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cvt_valid,
  input  logic [CH_W-1:0]   cvt_ch,
  input  logic              rd_req,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              mode_wr,
  input  logic              cal_start,
  input  logic              cal_done,
  output logic              busy,
  output logic [NUM_CH-1:0] flags
);
  logic [NUM_CH-1:0] flag_q, flag_d, pend_q, pend_d, cvt_oh, rd_oh;
  logic busy_q, cvt_fire, clr_all, set_all;

  assign cvt_fire = cvt_valid & ~busy_q;
  assign clr_all  = mode_wr | cal_start | (busy_q & ~cal_done);
  assign set_all  = busy_q & cal_done;

  always_comb begin
    cvt_oh = '0;
    rd_oh  = '0;
    if (cvt_fire) cvt_oh[cvt_ch] = 1'b1;
    if (rd_req)   rd_oh[rd_ch]   = 1'b1;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic f_nx, p_nx;
    always_comb begin
      p_nx = 1'b0;
      if (clr_all)                                f_nx = 1'b0;
      else if (set_all)                           f_nx = 1'b1;
      else if (cvt_oh[i] && (!flag_q[i] || rd_oh[i])) f_nx = 1'b1;
      else if (cvt_oh[i]) begin
        f_nx = 1'b0;
        p_nx = 1'b1;
      end
      else if (rd_oh[i])                          f_nx = 1'b0;
      else if (pend_q[i])                         f_nx = 1'b1;
      else                                        f_nx = flag_q[i];
    end
    assign flag_d[i] = f_nx;
    assign pend_d[i] = p_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
      if (cal_start)     busy_q <= 1'b1;
      else if (cal_done) busy_q <= 1'b0;
    end
  end

  assign flags = flag_q;
  assign busy  = busy_q;
endmodule

// File: rtl/rdy_result_bank.sv
module rdy_result_bank #(
  parameter int NUM_CH  = 8,
  parameter int CH_W    = $clog2(NUM_CH),
  parameter int DATA_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_short,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - SHORT_W;

  logic [DATA_W-1:0] mem_q [NUM_CH];
  logic [DATA_W-1:0] sel_word, rd_word;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                        mem_q[i] <= '0;
      else if (wr_en && wr_ch == CH_W'(i)) mem_q[i] <= wr_data;
    end
  end

  assign sel_word = mem_q[rd_ch];
  assign rd_word  = rd_short ? {{PAD_W{1'b0}}, sel_word[DATA_W-1 -: SHORT_W]} : sel_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_req;
      if (rd_req) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/rdy_pin_fn.sv
module rdy_pin_fn
  import rdy_trk_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] chan_en,
  input  pin_fn_e           fn,
  output logic              rdy_n
);
  logic any_set, all_set;
  assign any_set = |flags;
  assign all_set = (chan_en != '0) && ((flags & chan_en) == chan_en);
  assign rdy_n   = (fn == PIN_ALL) ? ~all_set : ~any_set;
endmodule

// File: rtl/rdy_tracker.sv
module rdy_tracker
  import rdy_trk_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 24,
  parameter int SHORT_W = 16,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cvt_valid,
  output logic              cvt_ready,
  input  logic [CH_W-1:0]   cvt_ch,
  input  logic [DATA_W-1:0] cvt_data,
  input  logic              rd_req,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_short,
  output logic              rd_data_vld,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mode_wr,
  input  logic              cal_start,
  input  logic              cal_done,
  input  logic              rdy_fn,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] status,
  output logic              rdy_n
);
  logic busy;

  rdy_flag_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .cvt_valid(cvt_valid), .cvt_ch(cvt_ch),
    .rd_req(rd_req), .rd_ch(rd_ch), .mode_wr(mode_wr),
    .cal_start(cal_start), .cal_done(cal_done), .busy(busy), .flags(status)
  );

  rdy_result_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cvt_valid & ~busy), .wr_ch(cvt_ch),
    .wr_data(cvt_data), .rd_req(rd_req), .rd_ch(rd_ch), .rd_short(rd_short),
    .rd_vld(rd_data_vld), .rd_data(rd_data)
  );

  rdy_pin_fn #(.NUM_CH(NUM_CH)) u_pin (
    .flags(status), .chan_en(chan_en), .fn(pin_fn_e'(rdy_fn)), .rdy_n(rdy_n)
  );

  assign cvt_ready = ~busy;
endmodule

// File: rtl/rdy_tracker_chk.sv
module rdy_tracker_chk #(
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 24,
  parameter int SHORT_W = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PAD_W  = DATA_W - SHORT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cvt_valid,
  input logic              cvt_ready,
  input logic [CH_W-1:0]   cvt_ch,
  input logic              rd_req,
  input logic [CH_W-1:0]   rd_ch,
  input logic              rd_short,
  input logic              rd_data_vld,
  input logic [DATA_W-1:0] rd_data,
  input logic              mode_wr,
  input logic              cal_start,
  input logic              cal_done,
  input logic              rdy_fn,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] status,
  input logic              rdy_n
);
  logic quiet;
  assign quiet = !mode_wr && !cal_start;

  AST_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_valid && cvt_ready && quiet && (!status[cvt_ch] || (rd_req && rd_ch == cvt_ch)))
    |=> status[$past(cvt_ch)]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cvt_ready && !cvt_valid && quiet) |=> !status[$past(rd_ch)]); // R3
  AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_data_vld); // R3
  AST_OVERWRITE_DIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_valid && cvt_ready && quiet && status[cvt_ch] && !(rd_req && rd_ch == cvt_ch))
    |=> !status[$past(cvt_ch)]); // R5
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (status == '0)); // R6
  AST_CAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (status == '0) && !cvt_ready); // R7
  AST_CAL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cvt_ready && cal_done && quiet) |=> (status == '1) && cvt_ready); // R7
  AST_PIN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_fn |-> (rdy_n == (status == '0))); // R8
  AST_PIN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_fn && chan_en != '0 && ((status & chan_en) == chan_en)) |-> !rdy_n); // R9
  AST_SHORT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_short) |=> (rd_data[DATA_W-1 -: PAD_W] == '0)); // R10
endmodule

bind rdy_tracker rdy_tracker_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cvt_valid(cvt_valid), .cvt_ready(cvt_ready), .cvt_ch(cvt_ch),
  .rd_req(rd_req), .rd_ch(rd_ch), .rd_short(rd_short), .rd_data_vld(rd_data_vld),
  .rd_data(rd_data), .mode_wr(mode_wr), .cal_start(cal_start), .cal_done(cal_done),
  .rdy_fn(rdy_fn), .chan_en(chan_en), .status(status), .rdy_n(rdy_n)
);

// File: tb/rdy_tracker_bench.sv
`timescale 1ns/1ps
module rdy_tracker_bench;
  localparam int NC = 8, CW = 3, DW = 24, SW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic cvt_valid = 0, rd_req = 0, rd_short = 0, mode_wr = 0, cal_start = 0, cal_done = 0, rdy_fn = 0;
  logic [CW-1:0] cvt_ch = 0, rd_ch = 0;
  logic [DW-1:0] cvt_data = 0;
  logic [NC-1:0] chan_en = 0;
  logic cvt_ready, rd_data_vld, rdy_n;
  logic [DW-1:0] rd_data;
  logic [NC-1:0] status;

  always #10 clk = ~clk;

  rdy_tracker u_rdy_tracker (
    .clk(clk), .rst_n(rst_n), .cvt_valid(cvt_valid), .cvt_ready(cvt_ready), .cvt_ch(cvt_ch),
    .cvt_data(cvt_data), .rd_req(rd_req), .rd_ch(rd_ch), .rd_short(rd_short),
    .rd_data_vld(rd_data_vld), .rd_data(rd_data), .mode_wr(mode_wr), .cal_start(cal_start),
    .cal_done(cal_done), .rdy_fn(rdy_fn), .chan_en(chan_en), .status(status), .rdy_n(rdy_n)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit in_cal = 0;

  // behavioural reference
  int m_mem [NC];
  bit m_flag [NC];
  bit m_pend [NC];
  bit m_busy = 0, m_vld = 0;
  int m_rdata = 0;

  initial for (int i = 0; i < NC; i++) begin m_mem[i] = 0; m_flag[i] = 0; m_pend[i] = 0; end

  always @(posedge clk) begin
    bit acc, wipe, fill;
    bit nf [NC];
    bit np [NC];
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_mem[i] = 0; m_flag[i] = 0; m_pend[i] = 0; end
      m_busy = 0; m_vld = 0; m_rdata = 0;
    end else begin
      acc  = cvt_valid && !m_busy;
      wipe = mode_wr || cal_start || (m_busy && !cal_done);
      fill = m_busy && cal_done;
      m_vld = rd_req;
      if (rd_req) m_rdata = rd_short ? (m_mem[rd_ch] >> (DW - SW)) : m_mem[rd_ch];
      for (int i = 0; i < NC; i++) begin
        bit c, r;
        c = acc && (cvt_ch == i);
        r = rd_req && (rd_ch == i);
        np[i] = 0;
        if (wipe) nf[i] = 0;
        else if (fill) nf[i] = 1;
        else if (c && m_flag[i] && !r) begin nf[i] = 0; np[i] = 1; end
        else if (c) nf[i] = 1;
        else if (m_pend[i] && !r) nf[i] = 1;
        else if (r) nf[i] = 0;
        else nf[i] = m_flag[i];
      end
      for (int i = 0; i < NC; i++) begin m_flag[i] = nf[i]; m_pend[i] = np[i]; end
      if (acc) m_mem[cvt_ch] = int'(cvt_data);
      if (cal_start) m_busy = 1; else if (cal_done) m_busy = 0;
    end
  end

  function automatic logic [NC-1:0] m_status();
    logic [NC-1:0] s;
    for (int i = 0; i < NC; i++) s[i] = m_flag[i];
    return s;
  endfunction

  function automatic logic m_rdy_n();
    logic [NC-1:0] s;
    s = m_status();
    if (rdy_fn) return !((chan_en != 0) && ((s & chan_en) == chan_en));
    return (s == 0);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, "status", 32'(status), 32'(m_status()));
    check(cur_req, "rdy_n", 32'(rdy_n), 32'(m_rdy_n()));
    check(cur_req, "cvt_ready", 32'(cvt_ready), 32'(!m_busy));
    check(cur_req, "rd_data_vld", 32'(rd_data_vld), 32'(m_vld));
    if (m_vld) check(cur_req, "rd_data", 32'(rd_data), 32'(m_rdata));
  end

  task automatic cyc();
    @(posedge clk); #1;
    cvt_valid = 0; rd_req = 0; mode_wr = 0; cal_start = 0; cal_done = 0; rd_short = 0;
  endtask

  task automatic put(int ch, int d);
    cvt_valid = 1; cvt_ch = CW'(ch); cvt_data = DW'(d); cyc();
  endtask

  task automatic get(int ch, bit sh);
    rd_req = 1; rd_ch = CW'(ch); rd_short = sh; cyc();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    @(negedge clk);
    check("R1", "status in reset", 32'(status), 0);
    check("R1", "rdy_n in reset", 32'(rdy_n), 1);
    check("R1", "cvt_ready in reset", 32'(cvt_ready), 1);
    rst_n = 1;
    cyc();
    get(0, 0);
    @(negedge clk);
    check("R1", "data after reset", 32'(rd_data), 0);

    cur_req = "R2";
    put(3, 24'hA1B2C3);
    @(negedge clk);
    check("R2", "flag ch3 set", 32'(status), 32'h08);
    check("R8", "rdy_n any", 32'(rdy_n), 0);

    cur_req = "R5";
    put(3, 24'h123456);
    @(negedge clk);
    check("R5", "flag dips on overwrite", 32'(status[3]), 0);
    @(negedge clk);
    check("R5", "flag back after overwrite", 32'(status[3]), 1);

    cur_req = "R3";
    get(3, 0);
    @(negedge clk);
    check("R3", "read data", 32'(rd_data), 32'h123456);
    check("R3", "flag cleared", 32'(status), 0);

    cur_req = "R10";
    put(5, 24'hFEDCBA);
    get(5, 1);
    @(negedge clk);
    check("R10", "short read", 32'(rd_data), 32'h00FEDC);

    cur_req = "R4";
    put(2, 24'h000111);
    get(2, 0);
    rd_req = 1; rd_ch = 2; cvt_valid = 1; cvt_ch = 2; cvt_data = 24'h000222; cyc();
    @(negedge clk);
    check("R4", "collision flag set", 32'(status[2]), 1);
    check("R11", "read sees old value", 32'(rd_data), 32'h000111);

    cur_req = "R5";
    put(6, 24'h00AAAA);
    cvt_valid = 1; cvt_ch = 6; cvt_data = 24'h00BBBB; cyc();
    get(6, 0);
    @(negedge clk);
    check("R5", "read during dip keeps low", 32'(status[6]), 0);
    @(negedge clk);
    check("R5", "still low", 32'(status[6]), 0);

    cur_req = "R9";
    rdy_fn = 1; chan_en = 8'h03;
    put(0, 24'h10);
    @(negedge clk);
    check("R9", "one of two enabled", 32'(rdy_n), 1);
    put(1, 24'h11);
    @(negedge clk);
    check("R9", "all enabled set", 32'(rdy_n), 0);
    chan_en = 8'h00;
    @(negedge clk);
    check("R9", "empty mask", 32'(rdy_n), 1);
    rdy_fn = 0;

    cur_req = "R6";
    mode_wr = 1; cvt_valid = 1; cvt_ch = 7; cvt_data = 24'h777777; cyc();
    @(negedge clk);
    check("R6", "mode write clears all", 32'(status), 0);
    get(7, 0);
    @(negedge clk);
    check("R6", "data still stored", 32'(rd_data), 32'h777777);

    cur_req = "R7";
    put(4, 24'h44);
    cal_start = 1; cyc();
    @(negedge clk);
    check("R7", "cal clears", 32'(status), 0);
    check("R7", "cal refuses", 32'(cvt_ready), 0);
    put(4, 24'h99);
    @(negedge clk);
    check("R7", "flags held low", 32'(status), 0);
    cal_done = 1; cyc();
    @(negedge clk);
    check("R7", "cal fills", 32'(status), 32'hFF);
    get(4, 0);
    @(negedge clk);
    check("R7", "refused result dropped", 32'(rd_data), 32'h44);

    cur_req = "MIX";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      cvt_valid = ($urandom_range(0, 2) != 0);
      cvt_ch = CW'($urandom_range(0, NC - 1));
      cvt_data = DW'($urandom);
      rd_req = ($urandom_range(0, 2) == 0);
      rd_ch = CW'($urandom_range(0, NC - 1));
      rd_short = $urandom_range(0, 1);
      mode_wr = (r < 3);
      if (!in_cal && r >= 97) begin cal_start = 1; in_cal = 1; end
      else if (in_cal && r >= 80) begin cal_done = 1; in_cal = 0; end
      if (k % 200 == 0) begin rdy_fn = $urandom_range(0, 1); chan_en = NC'($urandom); end
      cyc();
    end
    if (in_cal) begin cal_done = 1; cyc(); end
    repeat (3) cyc();
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule